// File: doc/BRIEF.md
# Programmable Serial Output Bit Mapper

This block takes the current and previous 20-bit samples of two channels, A and B, and serialises them onto four output lanes. Each channel has one primary and one secondary lane. The bit sent in each serial slot comes from a software-written table of 7-bit bit identifiers. An identifier names one bit of one sample of either channel, current or previous. With this table, software can split a sample across two lanes in any order, send the previous sample next to the current one, send a redundant copy on the secondary lane, or interleave both channels on a single lane.

Software writes the tables through a one-cycle write port. Each channel has 40 slots at its own address window. Writes go into a shadow copy. At each frame boundary, the block copies the shadow table into the working table. At the same boundary it captures the lane mode, the redundancy enable, the frame length and the four input samples. A frame therefore never mixes old and new settings or data. A frame strobe marks slot 0 of every frame.

Top module: `serial_bit_mapper`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, all four lanes and `frame_sync` are 0.
- R2: A bit identifier is decoded from its bit fields as follows. Bit 6 is 1 for the current sample and 0 for the previous sample. Bit 2 is 1 for channel A and 0 for channel B. The value v = {bits 5:3, bits 1:0} selects sample bit v-2 when 2 <= v <= 21. Examples: A current D19 = 0x6D, A current D0 = 0x46, B current D19 = 0x69, A previous D19 = 0x2D.
- R3: A write with `map_we` high stores `map_data` into a slot. Channel A slot n is at address 0x39+n and channel B slot n is at address 0x61+n, for n from 0 to 39. Writes to any other address change nothing.
- R4: After reset, in each channel, slots 0..19 hold current-sample bits D19 down to D0, and slots 20..39 hold previous-sample bits D19 down to D0.
- R5: In two-lane mode (`lane_mode` 0, and also code 3), at frame position c:
  - each channel's primary lane sends slot c of its own table;
  - each channel's secondary lane sends slot c+20 of its own table.
- R6: In one-lane mode (`lane_mode` 1), the primary lanes behave as in R5. The secondary lanes are 0 unless `dup_en` is 1, in which case they send slot c+20.
- R7: In shared-lane mode (`lane_mode` 2), only `tx_a0` carries data, sending channel A slot c for c from 0 to length-1. `tx_a1`, `tx_b0` and `tx_b1` stay 0.
- R8: A slot whose identifier falls outside the R2 range sends 0 (for example 0x00, 0x45, 0x6E, 0x7F).
- R9: The frame length is `frame_len`. A value of 0, or a value above the mode's maximum, gives the maximum. The maximum is 20 in two-lane and one-lane modes and 40 in shared-lane mode.
- R10: Table writes, the mode, `dup_en`, `frame_len` and the four samples are taken only at a frame boundary. A change during a frame leaves that frame unchanged and appears from the next frame.
- R11: The first rising edge after reset only loads settings. Slot s of a frame appears on the lanes after the (s+1)-th edge following its load edge. `frame_sync` is 1 exactly during slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_a | input | 20 | Channel A current sample |
| prev_a | input | 20 | Channel A previous sample |
| cur_b | input | 20 | Channel B current sample |
| prev_b | input | 20 | Channel B previous sample |
| map_we | input | 1 | Table write strobe |
| map_addr | input | 8 | Table write address |
| map_data | input | 7 | Bit identifier to store |
| lane_mode | input | 2 | 0 two-lane, 1 one-lane, 2 shared-lane, 3 as two-lane |
| dup_en | input | 1 | Redundant secondary lanes in one-lane mode |
| frame_len | input | 6 | Slots per frame; 0 means maximum |
| tx_a0 | output | 1 | Channel A primary lane |
| tx_a1 | output | 1 | Channel A secondary lane |
| tx_b0 | output | 1 | Channel B primary lane |
| tx_b1 | output | 1 | Channel B secondary lane |
| frame_sync | output | 1 | High during slot 0 |

## Verification
Every lane bit is due one edge after its slot position is counted. Position 0 of a frame follows the load edge by one edge, so the first frame after reset shows slot 0 after the second edge. The scoreboard avoids counting edges for normal frames. It holds the settings still for longer than two maximum frames, then aligns on the next `frame_sync` and compares one queued item per cycle at the falling edge. The reset and first-frame checks count edges explicitly. The boundary check changes the table and the samples after alignment, inside a frame, so the expected old frame and the expected new frame are due back to back.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  localparam int SAMPLE_W   = 20;
  localparam int ID_W       = 7;
  localparam int SLOTS      = 40;
  localparam int LANE_SLOTS = 20;
  localparam int IDX_W      = $clog2(SLOTS);
  localparam int LEN_W      = $clog2(SLOTS + 1);

  typedef enum logic [1:0] {
    MODE_TWO    = 2'b00,
    MODE_ONE    = 2'b01,
    MODE_SHARED = 2'b10,
    MODE_ALT    = 2'b11
  } lane_mode_e;

  typedef logic [SLOTS-1:0][ID_W-1:0] slot_tab_t;

  typedef struct packed {
    logic       valid;
    logic       use_cur;
    logic       chan_b;
    logic [4:0] pos;
  } bit_ref_t;

  // Field split of an identifier: [6] sample age, [2] channel, {[5:3],[1:0]} position + 2
  function automatic bit_ref_t decode_id(input logic [ID_W-1:0] id);
    bit_ref_t   r;
    logic [4:0] raw;
    raw       = {id[5:3], id[1:0]};
    r.use_cur = id[6];
    r.chan_b  = ~id[2];
    r.valid   = (raw >= 5'd2) && (raw <= 5'd21);
    r.pos     = raw - 5'd2;
    return r;
  endfunction

  function automatic logic [ID_W-1:0] ident_id(input int slot, input bit chan_b);
    logic [4:0] raw;
    logic       cur;
    if (slot < LANE_SLOTS) begin
      cur = 1'b1;
      raw = 5'(LANE_SLOTS + 1 - slot);
    end else begin
      cur = 1'b0;
      raw = 5'(SLOTS + 1 - slot);
    end
    return {cur, raw[4:2], ~chan_b, raw[1:0]};
  endfunction

  function automatic slot_tab_t ident_table(input bit chan_b);
    slot_tab_t t;
    for (int s = 0; s < SLOTS; s++) t[s] = ident_id(s, chan_b);
    return t;
  endfunction

  function automatic logic fetch_bit(input bit_ref_t r,
                                     input logic [SAMPLE_W-1:0] ca, pa, cb, pb);
    logic [SAMPLE_W-1:0] src;
    case ({r.chan_b, r.use_cur})
      2'b01:   src = ca;
      2'b00:   src = pa;
      2'b11:   src = cb;
      default: src = pb;
    endcase
    return r.valid ? src[r.pos] : 1'b0;
  endfunction
endpackage

// File: rtl/sbm_slot_table.sv
module sbm_slot_table
  import sbm_pkg::*;
#(
  parameter int                ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE   = 8'h39,
  parameter bit                CHAN_B = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ID_W-1:0]   wr_data,
  input  logic              commit,
  output slot_tab_t         active
);
  localparam slot_tab_t INIT_TAB = ident_table(CHAN_B);

  logic [ADDR_W-1:0] offset;
  logic              hit;
  slot_tab_t         shadow;

  assign offset = wr_addr - BASE;
  assign hit    = wr_en && (wr_addr >= BASE) && (offset < ADDR_W'(SLOTS));

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= INIT_TAB;
      active <= INIT_TAB;
    end else begin
      if (hit) shadow[offset[IDX_W-1:0]] <= wr_data;
      if (commit) active <= shadow;
    end
  end

  // R10: the working table only moves at a frame boundary
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(active))
    else $error("working table changed inside a frame");
endmodule

// File: rtl/sbm_frame_ctrl.sv
module sbm_frame_ctrl
  import sbm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  lane_mode_e       mode_in,
  input  logic             dup_in,
  input  logic [LEN_W-1:0] len_in,
  output logic             started,
  output logic             commit,
  output logic [IDX_W-1:0] cnt,
  output lane_mode_e       mode_q,
  output logic             dup_q
);
  logic [IDX_W-1:0] last_q;
  logic [LEN_W-1:0] max_len;
  logic [LEN_W-1:0] len_eff;

  always_comb begin
    max_len = (mode_in == MODE_SHARED) ? LEN_W'(SLOTS) : LEN_W'(LANE_SLOTS);
    len_eff = ((len_in == '0) || (len_in > max_len)) ? max_len : len_in;
  end

  assign commit = !started || (cnt == last_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      started <= 1'b0;
      cnt     <= '0;
      last_q  <= IDX_W'(LANE_SLOTS - 1);
      mode_q  <= MODE_TWO;
      dup_q   <= 1'b0;
    end else begin
      started <= 1'b1;
      if (commit) begin
        cnt    <= '0;
        last_q <= IDX_W'(len_eff - 1'b1);
        mode_q <= mode_in;
        dup_q  <= dup_in;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R9: position never passes the frame's last slot
  p_cnt_range_r9: assert property (@(posedge clk) disable iff (rst)
    started |-> (cnt <= last_q))
    else $error("slot position beyond frame end");

  // R9: lane-pair modes never run past 20 slots
  p_len_cap_r9: assert property (@(posedge clk) disable iff (rst)
    (started && mode_q != MODE_SHARED) |-> (last_q < IDX_W'(LANE_SLOTS)))
    else $error("frame longer than a lane half");
endmodule

// File: rtl/sbm_lane_out.sv
module sbm_lane_out
  import sbm_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      started,
  input  logic                      commit,
  input  logic [IDX_W-1:0]          cnt,
  input  lane_mode_e                mode_q,
  input  logic                      dup_q,
  input  logic [1:0][SLOTS-1:0][ID_W-1:0] tabs,
  input  logic [SAMPLE_W-1:0]       cur_a,
  input  logic [SAMPLE_W-1:0]       prev_a,
  input  logic [SAMPLE_W-1:0]       cur_b,
  input  logic [SAMPLE_W-1:0]       prev_b,
  output logic                      tx_a0,
  output logic                      tx_a1,
  output logic                      tx_b0,
  output logic                      tx_b1,
  output logic                      frame_sync
);
  logic [SAMPLE_W-1:0] s_ca, s_pa, s_cb, s_pb;
  logic [IDX_W-1:0]    sec_idx;
  logic                sec_in_range;
  logic [1:0]          prim_bit, sec_bit, prim_ok;

  assign sec_idx      = cnt + IDX_W'(LANE_SLOTS);
  assign sec_in_range = sec_idx < IDX_W'(SLOTS);

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic [ID_W-1:0] prim_id, sec_id;
    bit_ref_t        prim_ref, sec_ref;
    assign prim_id      = tabs[ch][cnt];
    assign sec_id       = sec_in_range ? tabs[ch][sec_idx] : '0;
    assign prim_ref     = decode_id(prim_id);
    assign sec_ref      = decode_id(sec_id);
    assign prim_ok[ch]  = prim_ref.valid;
    assign prim_bit[ch] = fetch_bit(prim_ref, s_ca, s_pa, s_cb, s_pb);
    assign sec_bit[ch]  = fetch_bit(sec_ref, s_ca, s_pa, s_cb, s_pb);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {tx_a0, tx_a1, tx_b0, tx_b1, frame_sync} <= '0;
      s_ca <= '0;
      s_pa <= '0;
      s_cb <= '0;
      s_pb <= '0;
    end else begin
      if (commit) begin
        s_ca <= cur_a;
        s_pa <= prev_a;
        s_cb <= cur_b;
        s_pb <= prev_b;
      end
      if (!started) begin
        {tx_a0, tx_a1, tx_b0, tx_b1, frame_sync} <= '0;
      end else begin
        frame_sync <= (cnt == '0);
        case (mode_q)
          MODE_SHARED: begin
            tx_a0 <= prim_bit[0];
            tx_a1 <= 1'b0;
            tx_b0 <= 1'b0;
            tx_b1 <= 1'b0;
          end
          MODE_ONE: begin
            tx_a0 <= prim_bit[0];
            tx_a1 <= dup_q & sec_bit[0];
            tx_b0 <= prim_bit[1];
            tx_b1 <= dup_q & sec_bit[1];
          end
          default: begin
            tx_a0 <= prim_bit[0];
            tx_a1 <= sec_bit[0];
            tx_b0 <= prim_bit[1];
            tx_b1 <= sec_bit[1];
          end
        endcase
      end
    end
  end

  // R7: shared-lane mode leaves three lanes idle
  p_shared_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (started && mode_q == MODE_SHARED) |=> (!tx_a1 && !tx_b0 && !tx_b1))
    else $error("idle lane active in shared mode");

  // R6: no redundant copy unless enabled
  p_dup_off_r6: assert property (@(posedge clk) disable iff (rst)
    (started && mode_q == MODE_ONE && !dup_q) |=> (!tx_a1 && !tx_b1))
    else $error("secondary lane active without copy enable");

  // R8: an undecodable identifier sends zero
  p_bad_id_r8: assert property (@(posedge clk) disable iff (rst)
    (started && !prim_ok[0]) |=> !tx_a0)
    else $error("invalid identifier produced a one");
endmodule

// File: rtl/serial_bit_mapper.sv
module serial_bit_mapper
  import sbm_pkg::*;
#(
  parameter int                ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_A = 8'h39,
  parameter logic [ADDR_W-1:0] BASE_B = 8'h61
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] cur_a,
  input  logic [SAMPLE_W-1:0] prev_a,
  input  logic [SAMPLE_W-1:0] cur_b,
  input  logic [SAMPLE_W-1:0] prev_b,
  input  logic                map_we,
  input  logic [ADDR_W-1:0]   map_addr,
  input  logic [ID_W-1:0]     map_data,
  input  logic [1:0]          lane_mode,
  input  logic                dup_en,
  input  logic [LEN_W-1:0]    frame_len,
  output logic                tx_a0,
  output logic                tx_a1,
  output logic                tx_b0,
  output logic                tx_b1,
  output logic                frame_sync
);
  logic                           started, commit, dup_q;
  logic [IDX_W-1:0]               cnt;
  lane_mode_e                     mode_q;
  logic [1:0][SLOTS-1:0][ID_W-1:0] tabs;

  sbm_frame_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .mode_in (lane_mode_e'(lane_mode)),
    .dup_in  (dup_en),
    .len_in  (frame_len),
    .started (started),
    .commit  (commit),
    .cnt     (cnt),
    .mode_q  (mode_q),
    .dup_q   (dup_q)
  );

  sbm_slot_table #(.ADDR_W(ADDR_W), .BASE(BASE_A), .CHAN_B(1'b0)) u_tab_a (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (map_we),
    .wr_addr (map_addr),
    .wr_data (map_data),
    .commit  (commit),
    .active  (tabs[0])
  );

  sbm_slot_table #(.ADDR_W(ADDR_W), .BASE(BASE_B), .CHAN_B(1'b1)) u_tab_b (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (map_we),
    .wr_addr (map_addr),
    .wr_data (map_data),
    .commit  (commit),
    .active  (tabs[1])
  );

  sbm_lane_out u_out (
    .clk        (clk),
    .rst        (rst),
    .started    (started),
    .commit     (commit),
    .cnt        (cnt),
    .mode_q     (mode_q),
    .dup_q      (dup_q),
    .tabs       (tabs),
    .cur_a      (cur_a),
    .prev_a     (prev_a),
    .cur_b      (cur_b),
    .prev_b     (prev_b),
    .tx_a0      (tx_a0),
    .tx_a1      (tx_a1),
    .tx_b0      (tx_b0),
    .tx_b1      (tx_b1),
    .frame_sync (frame_sync)
  );
endmodule

// File: tb/serial_bit_mapper_bench.sv
module serial_bit_mapper_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [19:0] cur_a, prev_a, cur_b, prev_b;
  logic        map_we;
  logic [7:0]  map_addr;
  logic [6:0]  map_data;
  logic [1:0]  lane_mode;
  logic        dup_en;
  logic [5:0]  frame_len;
  logic        tx_a0, tx_a1, tx_b0, tx_b1, frame_sync;

  always #4 clk = ~clk;

  serial_bit_mapper u_serial_bit_mapper (
    .clk(clk), .rst(rst), .cur_a(cur_a), .prev_a(prev_a), .cur_b(cur_b), .prev_b(prev_b),
    .map_we(map_we), .map_addr(map_addr), .map_data(map_data), .lane_mode(lane_mode),
    .dup_en(dup_en), .frame_len(frame_len), .tx_a0(tx_a0), .tx_a1(tx_a1),
    .tx_b0(tx_b0), .tx_b1(tx_b1), .frame_sync(frame_sync)
  );

  typedef struct packed { logic sync, a0, a1, b0, b1; } beat_t;

  // R2: channel A current-sample identifiers, index = sample bit
  localparam logic [6:0] CUR_A_ID [20] = '{
    7'h46, 7'h47, 7'h4C, 7'h4D, 7'h4E, 7'h4F, 7'h54, 7'h55, 7'h56, 7'h57,
    7'h5C, 7'h5D, 7'h5E, 7'h5F, 7'h64, 7'h65, 7'h66, 7'h67, 7'h6C, 7'h6D};

  int         n_checks = 0;
  int         n_fail   = 0;
  int         cyc      = 0;
  logic [6:0] tbl [2][40];
  beat_t      exp_q[$];
  string      tag_q[$];
  bit         armed   = 1'b0;
  bit         aligned = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  function automatic logic mbit(input logic [6:0] id);
    logic [19:0] s;
    for (int ch = 0; ch < 2; ch++)
      for (int pv = 0; pv < 2; pv++)
        for (int d = 0; d < 20; d++)
          if (id == CUR_A_ID[d] - 7'(pv * 64) - 7'(ch * 4)) begin
            s = (ch == 0) ? ((pv == 0) ? cur_a : prev_a) : ((pv == 0) ? cur_b : prev_b);
            return s[d];
          end
    return 1'b0;  // R8: unknown identifier
  endfunction

  function automatic int eff_len();
    int mx;
    mx = (lane_mode == 2'd2) ? 40 : 20;  // R9
    return (frame_len == 0 || int'(frame_len) > mx) ? mx : int'(frame_len);
  endfunction

  // Driver side of the scoreboard: queue one frame of expected beats
  task automatic push_frame(input string tag);
    int    len;
    beat_t b;
    len = eff_len();
    for (int c = 0; c < len; c++) begin
      case (lane_mode)
        2'd2:    b = {c == 0, mbit(tbl[0][c]), 1'b0, 1'b0, 1'b0};
        2'd1:    b = {c == 0, mbit(tbl[0][c]), dup_en & mbit(tbl[0][c+20]),
                      mbit(tbl[1][c]), dup_en & mbit(tbl[1][c+20])};
        default: b = {c == 0, mbit(tbl[0][c]), mbit(tbl[0][c+20]),
                      mbit(tbl[1][c]), mbit(tbl[1][c+20])};
      endcase
      exp_q.push_back(b);
      tag_q.push_back(tag);
    end
    armed = 1'b1;
  endtask

  task automatic run_frame(input string tag);
    repeat (90) @(posedge clk);
    #1;
    push_frame(tag);
    wait (!armed);
  endtask

  task automatic wr(input logic [7:0] a, input logic [6:0] d);
    @(negedge clk);
    map_we = 1'b1; map_addr = a; map_data = d;
    @(negedge clk);
    map_we = 1'b0;
    // R3: address windows
    if (a >= 8'h39 && a <= 8'h60) tbl[0][a - 8'h39] = d;
    else if (a >= 8'h61 && a <= 8'h88) tbl[1][a - 8'h61] = d;
  endtask

  // Monitor side: align on the strobe, then pop one beat per cycle
  always @(negedge clk) begin
    beat_t got, exp;
    string tag;
    if (armed) begin
      if (!aligned && frame_sync) aligned = 1'b1;
      if (aligned && exp_q.size() > 0) begin
        got = {frame_sync, tx_a0, tx_a1, tx_b0, tx_b1};
        exp = exp_q.pop_front();
        tag = tag_q.pop_front();
        check(got == exp, tag, 32'(got), 32'(exp));
        if (exp_q.size() == 0) begin
          armed   = 1'b0;
          aligned = 1'b0;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(1'b0, "R11 watchdog", 32'(cyc), 32'd150000);
      finish_run();
    end
  end

  initial begin
    rst = 1'b1;
    cur_a = 20'hB38E5; prev_a = 20'h4C1A7; cur_b = 20'h9F60D; prev_b = 20'h2D7B3;
    map_we = 1'b0; map_addr = '0; map_data = '0;
    lane_mode = 2'd0; dup_en = 1'b0; frame_len = 6'd0;
    // R4: identity tables
    for (int ch = 0; ch < 2; ch++)
      for (int s = 0; s < 40; s++)
        tbl[ch][s] = (s < 20) ? CUR_A_ID[19-s] - 7'(ch * 4)
                              : CUR_A_ID[39-s] - 7'h40 - 7'(ch * 4);

    repeat (4) @(negedge clk);
    check({frame_sync, tx_a0, tx_a1, tx_b0, tx_b1} == 5'b0, "R1 quiet in reset",
          32'({frame_sync, tx_a0, tx_a1, tx_b0, tx_b1}), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check({frame_sync, tx_a0, tx_a1, tx_b0, tx_b1} == 5'b0, "R1 R11 load edge only",
          32'({frame_sync, tx_a0, tx_a1, tx_b0, tx_b1}), 32'd0);
    @(negedge clk);
    check({frame_sync, tx_a0, tx_a1, tx_b0, tx_b1} ==
          {1'b1, cur_a[19], prev_a[19], cur_b[19], prev_b[19]}, "R11 R4 first slot",
          32'({frame_sync, tx_a0, tx_a1, tx_b0, tx_b1}),
          32'({1'b1, cur_a[19], prev_a[19], cur_b[19], prev_b[19]}));

    run_frame("R4 R5 identity two-lane");

    wr(8'h39, 7'h69); wr(8'h3A, 7'h0A); wr(8'h3B, 7'h46); wr(8'h3F, 7'h23);
    wr(8'h66, 7'h66); wr(8'h52, 7'h5C); wr(8'h88, 7'h2D);
    run_frame("R2 R3 cross-channel identifiers");

    wr(8'h3C, 7'h00); wr(8'h3D, 7'h45); wr(8'h3E, 7'h6E); wr(8'h63, 7'h7F);
    run_frame("R8 invalid identifiers");

    wr(8'h38, 7'h46); wr(8'h89, 7'h46); wr(8'hF0, 7'h00);
    run_frame("R3 ignored addresses");

    lane_mode = 2'd3;
    run_frame("R5 code 3 as two-lane");
    lane_mode = 2'd0;

    frame_len = 6'd12;
    run_frame("R9 short frame");
    frame_len = 6'd33;
    run_frame("R9 clamp to 20");
    frame_len = 6'd0;

    lane_mode = 2'd1; dup_en = 1'b0;
    run_frame("R6 one-lane no copy");
    dup_en = 1'b1;
    run_frame("R6 one-lane copy");

    lane_mode = 2'd2; dup_en = 1'b0;
    for (int k = 0; k < 20; k++) wr(8'(8'h39 + 20 + k), CUR_A_ID[19-k] - 7'd4);
    run_frame("R7 shared 40 slots");
    frame_len = 6'd30;
    run_frame("R7 R9 shared short");

    lane_mode = 2'd0; frame_len = 6'd20;
    repeat (90) @(posedge clk);
    #1;
    push_frame("R10 frame unchanged by mid-frame update");
    wait (aligned);
    cur_a = ~cur_a; prev_b = prev_b ^ 20'h5A5A5;
    wr(8'h39 + 8'd15, 7'h2D);
    wr(8'h61 + 8'd18, 7'h46);
    wait (!armed);
    push_frame("R10 next frame takes update");
    wait (!armed);

    finish_run();
  end
endmodule